// File: doc/BRIEF.md
# DDR2 Power-Up and Mode-Register Sequencer

This block drives the command, bank-address and address pins of a DDR2 memory from reset until the device is ready for normal traffic. After reset it sits idle. The clock enable is low and the command bus carries NOP. A single-cycle `start` pulse begins the bring-up. The block first holds the clock enable low for a programmable settling time. It then raises the clock enable, waits again, and issues a fixed list of commands. The list is a precharge-all, writes to the second, third and first extended registers, and a write to the main register that resets the DLL. These are followed by a second precharge-all, two refreshes, a write to the main register with the DLL reset cleared, and a pair of writes to the first extended register that loads the default drive calibration and then leaves calibration.

The contents of the register writes come from static configuration pins: burst length, burst ordering, CAS latency, write recovery, additive latency, output drive strength, termination value and DLL enable. The caller holds these pins steady for the whole sequence. Between commands the block drives NOP for a programmable gap, with a longer gap after each refresh. After the last write, a final wait runs and then `ready` rises and stays high. The control pins are plain levels. There is no data stream and no handshake.

Top module: `ddr2_boot_seq`

## Requirements
- R1: From reset until `start` is seen, `cke` is 0, `ready` is 0 and the bus carries NOP. NOP means `cs_n`=0 and `ras_n`, `cas_n`, `we_n`=1, with `ba` and `addr` all zero.
- R2: After the edge that samples `start`, `cke` stays 0 for exactly PWR_WAIT cycles of NOP. `cke` then rises and exactly CKE_WAIT NOP cycles pass before the first command.
- R3: Commands appear in this order: precharge-all, ext2 write, ext3 write, ext1 write, main write with DLL reset, precharge-all, refresh, refresh, main write without DLL reset, ext1 calibration-default write, ext1 calibration-exit write. The pin codes, as {cs_n,ras_n,cas_n,we_n}, are register write 0000, precharge 0010 with `addr[10]`=1 and the other address bits 0, and refresh 0001.
- R4: A register write selects its target with `ba`: 0 is the main register, 1 is ext1, 2 is ext2 and 3 is ext3. Precharge and refresh drive `ba`=0.
- R5: The main register word places the burst length code on bits 2:0 (2 for four beats, 3 for eight). Burst ordering goes on bit 3 (1 = interleaved). The CAS latency value goes on bits 6:4. Bit 7 is 0. The DLL reset goes on bit 8. Write recovery minus one goes on bits 11:9. Bit 12 is 0.
- R6: The ext1 word places DLL disable on bit 0 and reduced drive on bit 1. The termination select {bit 6, bit 2} = `cfg_odt_sel` (01 = 75 ohm, 10 = 150 ohm, 11 = 50 ohm, 00 = off). Additive latency goes on bits 5:3. Bits 12:10 are 0. Bits 9:7 are 0 except in the calibration-default write.
- R7: The ext2 and ext3 writes carry an all-zero address.
- R8: The calibration pair consists of two consecutive ext1 writes. The first has bits 9:7 = 111 and the second has them = 000. All other bits are identical in both and equal those of the earlier ext1 write.
- R9: Exactly GAP_WAIT NOP cycles follow each command except a refresh. Exactly RFC_WAIT NOP cycles follow each refresh.
- R10: After the last write, exactly FINAL_WAIT NOP cycles pass. `ready` then rises and remains 1 with NOP on the bus.
- R11: A `start` pulse while the sequence runs or after `ready` has no effect on the command stream or its timing.
- R12: Once raised, `cke` stays 1 until reset. No command other than NOP is driven while `cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins the bring-up when idle |
| cfg_burst8 | input | 1 | 1 = eight-beat bursts, 0 = four-beat |
| cfg_interleave | input | 1 | 1 = interleaved burst order |
| cfg_cas_lat | input | 3 | CAS latency in cycles (3..6) |
| cfg_write_rec | input | 3 | Write recovery in cycles (2..6) |
| cfg_add_lat | input | 3 | Additive latency in cycles (0..5) |
| cfg_drive_reduced | input | 1 | 1 = reduced output drive |
| cfg_odt_sel | input | 2 | Termination select code |
| cfg_dll_off | input | 1 | 1 = DLL disabled |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, low active |
| ras_n | output | 1 | Row strobe, low active |
| cas_n | output | 1 | Column strobe, low active |
| we_n | output | 1 | Write enable, low active |
| ba | output | 2 | Bank address / register select |
| addr | output | 13 | Address / register contents |
| ready | output | 1 | Bring-up complete |

## Verification
The bench sweeps 240 configurations. Each field runs through all of its legal values across the sweep, and bit positions differ between runs. A field placed at the wrong offset, or swapped with a neighbour, therefore gives a wrong word for some run. Every run replays the whole sequence and compares each command code, bank select and address word with values computed from the fields. It also measures every NOP gap, which separates the refresh gap from the ordinary gap and the settling waits from each other. A stray `start` is injected in mid-sequence and again after `ready`, and the command stream must not change.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

  localparam int ADDR_W = 13;

  typedef enum logic [3:0] {
    STEP_PREA0, STEP_EXT2, STEP_EXT3, STEP_EXT1, STEP_MAIN_RST, STEP_PREA1,
    STEP_REF0, STEP_REF1, STEP_MAIN_RUN, STEP_CAL_DFLT, STEP_CAL_EXIT
  } step_e;

  localparam step_e STEP_LAST = STEP_CAL_EXIT;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PWR, PH_CKE, PH_CMD, PH_GAP, PH_FINAL, PH_READY
  } phase_e;

  typedef enum logic [1:0] {CMD_NOP, CMD_PREA, CMD_REF, CMD_MRS} cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t cmd_pins(cmd_e c);
    pins_t p;
    case (c)
      CMD_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr2_boot_timer.sv
module ddr2_boot_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain <= '0;
    else if (load)             remain <= load_val;
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/ddr2_boot_words.sv
module ddr2_boot_words
  import ddr2_boot_pkg::*;
(
  input  step_e             step,
  input  logic              cfg_burst8,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_write_rec,
  input  logic [2:0]        cfg_add_lat,
  input  logic              cfg_drive_reduced,
  input  logic [1:0]        cfg_odt_sel,
  input  logic              cfg_dll_off,
  output cmd_e              cmd,
  output logic [1:0]        sel,
  output logic [ADDR_W-1:0] word
);
  localparam logic [1:0] SEL_MAIN = 2'd0;
  localparam logic [1:0] SEL_EXT1 = 2'd1;
  localparam logic [1:0] SEL_EXT2 = 2'd2;
  localparam logic [1:0] SEL_EXT3 = 2'd3;

  function automatic logic [ADDR_W-1:0] main_word(logic dll_rst, logic b8, logic il,
                                                  logic [2:0] cl, logic [2:0] wr);
    logic [ADDR_W-1:0] w;
    w        = '0;
    w[2:0]   = b8 ? 3'd3 : 3'd2;
    w[3]     = il;
    w[6:4]   = cl;
    w[7]     = 1'b0;
    w[8]     = dll_rst;
    w[11:9]  = wr - 3'd1;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] ext1_word(logic [2:0] cal, logic dll_off,
                                                  logic drv, logic [1:0] odt,
                                                  logic [2:0] al);
    logic [ADDR_W-1:0] w;
    w       = '0;
    w[0]    = dll_off;
    w[1]    = drv;
    w[2]    = odt[0];
    w[5:3]  = al;
    w[6]    = odt[1];
    w[9:7]  = cal;
    return w;
  endfunction

  always_comb begin
    cmd  = CMD_MRS;
    sel  = SEL_MAIN;
    word = '0;
    unique case (step)
      STEP_PREA0, STEP_PREA1: begin
        cmd      = CMD_PREA;
        word[10] = 1'b1;
      end
      STEP_REF0, STEP_REF1: cmd = CMD_REF;
      STEP_EXT2: sel = SEL_EXT2;
      STEP_EXT3: sel = SEL_EXT3;
      STEP_EXT1, STEP_CAL_EXIT: begin
        sel  = SEL_EXT1;
        word = ext1_word(3'b000, cfg_dll_off, cfg_drive_reduced, cfg_odt_sel, cfg_add_lat);
      end
      STEP_CAL_DFLT: begin
        sel  = SEL_EXT1;
        word = ext1_word(3'b111, cfg_dll_off, cfg_drive_reduced, cfg_odt_sel, cfg_add_lat);
      end
      STEP_MAIN_RST:
        word = main_word(1'b1, cfg_burst8, cfg_interleave, cfg_cas_lat, cfg_write_rec);
      STEP_MAIN_RUN:
        word = main_word(1'b0, cfg_burst8, cfg_interleave, cfg_cas_lat, cfg_write_rec);
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
  import ddr2_boot_pkg::*;
#(
  parameter int PWR_WAIT   = 40000,
  parameter int CKE_WAIT   = 80,
  parameter int GAP_WAIT   = 2,
  parameter int RFC_WAIT   = 26,
  parameter int FINAL_WAIT = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cfg_burst8,
  input  logic        cfg_interleave,
  input  logic [2:0]  cfg_cas_lat,
  input  logic [2:0]  cfg_write_rec,
  input  logic [2:0]  cfg_add_lat,
  input  logic        cfg_drive_reduced,
  input  logic [1:0]  cfg_odt_sel,
  input  logic        cfg_dll_off,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        ready
);
  localparam int MAX_A  = (PWR_WAIT > CKE_WAIT) ? PWR_WAIT : CKE_WAIT;
  localparam int MAX_B  = (GAP_WAIT > RFC_WAIT) ? GAP_WAIT : RFC_WAIT;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_W  = (MAX_C > FINAL_WAIT) ? MAX_C : FINAL_WAIT;
  localparam int CW     = $clog2(MAX_W + 1);

  localparam logic [CW-1:0] LD_PWR   = CW'(PWR_WAIT - 1);
  localparam logic [CW-1:0] LD_CKE   = CW'(CKE_WAIT - 1);
  localparam logic [CW-1:0] LD_GAP   = CW'(GAP_WAIT - 1);
  localparam logic [CW-1:0] LD_RFC   = CW'(RFC_WAIT - 1);
  localparam logic [CW-1:0] LD_FINAL = CW'(FINAL_WAIT - 1);

  phase_e            phase;
  step_e             step;
  logic              t_load;
  logic [CW-1:0]     t_val;
  logic              t_done;
  cmd_e              w_cmd;
  logic [1:0]        w_sel;
  logic [ADDR_W-1:0] w_word;
  pins_t             pins;
  logic              issuing;
  logic              is_ref;

  ddr2_boot_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  ddr2_boot_words u_words (
    .step              (step),
    .cfg_burst8        (cfg_burst8),
    .cfg_interleave    (cfg_interleave),
    .cfg_cas_lat       (cfg_cas_lat),
    .cfg_write_rec     (cfg_write_rec),
    .cfg_add_lat       (cfg_add_lat),
    .cfg_drive_reduced (cfg_drive_reduced),
    .cfg_odt_sel       (cfg_odt_sel),
    .cfg_dll_off       (cfg_dll_off),
    .cmd               (w_cmd),
    .sel               (w_sel),
    .word              (w_word)
  );

  assign is_ref = (step == STEP_REF0) || (step == STEP_REF1);

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (phase)
      PH_IDLE: if (start) begin
        t_load = 1'b1;
        t_val  = LD_PWR;
      end
      PH_PWR: if (t_done) begin
        t_load = 1'b1;
        t_val  = LD_CKE;
      end
      PH_CMD: begin
        t_load = 1'b1;
        if (step == STEP_LAST) t_val = LD_FINAL;
        else if (is_ref)       t_val = LD_RFC;
        else                   t_val = LD_GAP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= STEP_PREA0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (start)  phase <= PH_PWR;
        PH_PWR:   if (t_done) phase <= PH_CKE;
        PH_CKE:   if (t_done) begin
          phase <= PH_CMD;
          step  <= STEP_PREA0;
        end
        PH_CMD:   phase <= (step == STEP_LAST) ? PH_FINAL : PH_GAP;
        PH_GAP:   if (t_done) begin
          phase <= PH_CMD;
          step  <= step_e'(step + 4'd1);
        end
        PH_FINAL: if (t_done) phase <= PH_READY;
        default:  phase <= PH_READY;
      endcase
    end
  end

  assign issuing = (phase == PH_CMD);
  assign pins    = cmd_pins(issuing ? w_cmd : CMD_NOP);
  assign cs_n    = pins.cs_n;
  assign ras_n   = pins.ras_n;
  assign cas_n   = pins.cas_n;
  assign we_n    = pins.we_n;
  assign ba      = issuing ? w_sel  : 2'b00;
  assign addr    = issuing ? w_word : '0;
  assign cke     = (phase != PH_IDLE) && (phase != PH_PWR);
  assign ready   = (phase == PH_READY);
endmodule

// File: rtl/ddr2_boot_seq_chk.sv
module ddr2_boot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        ready
);
  logic nop_bus;
  logic mrs_bus;
  logic prea_bus;
  assign nop_bus  = !cs_n && ras_n && cas_n && we_n;
  assign mrs_bus  = !cs_n && !ras_n && !cas_n && !we_n;
  assign prea_bus = !cs_n && !ras_n && cas_n && !we_n;

  p_quiet_low_cke_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> nop_bus);
  p_cke_sticks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  p_ready_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (nop_bus && cke));
  p_ext3_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_bus && ba == 2'd3) |-> (addr == 13'd0));
  p_cal_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_bus && ba == 2'd1) |-> (addr[9:7] == 3'b000 || addr[9:7] == 3'b111));
  p_cmd_then_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !nop_bus |=> nop_bus);
  p_prea_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prea_bus |-> (addr[10] && ba == 2'd0));
endmodule

bind ddr2_boot_seq ddr2_boot_seq_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cke   (cke),
  .cs_n  (cs_n),
  .ras_n (ras_n),
  .cas_n (cas_n),
  .we_n  (we_n),
  .ba    (ba),
  .addr  (addr),
  .ready (ready)
);

// File: tb/test_ddr2_boot_seq.sv
module test_ddr2_boot_seq;
  localparam int PW = 12;
  localparam int CW = 5;
  localparam int GW = 2;
  localparam int RW = 7;
  localparam int FW = 9;
  localparam int RUNS = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cfg_burst8 = 1'b0, cfg_interleave = 1'b0, cfg_drive_reduced = 1'b0, cfg_dll_off = 1'b0;
  logic [2:0] cfg_cas_lat = 3'd3, cfg_write_rec = 3'd2, cfg_add_lat = 3'd0;
  logic [1:0] cfg_odt_sel = 2'd0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0] ba;
  logic [12:0] addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ddr2_boot_seq #(.PWR_WAIT(PW), .CKE_WAIT(CW), .GAP_WAIT(GW), .RFC_WAIT(RW), .FINAL_WAIT(FW))
  i_ddr2_boot_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst8(cfg_burst8), .cfg_interleave(cfg_interleave), .cfg_cas_lat(cfg_cas_lat),
    .cfg_write_rec(cfg_write_rec), .cfg_add_lat(cfg_add_lat),
    .cfg_drive_reduced(cfg_drive_reduced), .cfg_odt_sel(cfg_odt_sel), .cfg_dll_off(cfg_dll_off),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .ready(ready)
  );

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int bus();
    return {28'd0, cs_n, ras_n, cas_n, we_n};
  endfunction

  function automatic int main_exp(int rst);
    return (cfg_burst8 ? 3 : 2) + 8 * cfg_interleave + 16 * cfg_cas_lat + 256 * rst
           + 512 * (cfg_write_rec - 1);
  endfunction

  function automatic int ext1_exp(int cal);
    return cfg_dll_off + 2 * cfg_drive_reduced + 4 * cfg_odt_sel[0] + 8 * cfg_add_lat
           + 64 * cfg_odt_sel[1] + 128 * cal;
  endfunction

  task automatic run_one(int i);
    int cnt;
    int e_pins, e_ba, e_addr, e_gap;
    cfg_burst8        = i[0];
    cfg_interleave    = i[1];
    cfg_cas_lat       = 3'(3 + (i >> 2) % 4);
    cfg_write_rec     = 3'(2 + i % 5);
    cfg_add_lat       = 3'(i % 6);
    cfg_odt_sel       = 2'((i >> 1) % 4);
    cfg_drive_reduced = i[3];
    cfg_dll_off       = i[4];
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle state before start
    check("R1", "idle bus", {bus(), 3'b0, cke, ready, 2'b0, ba, 3'b0, addr},
          {32'h7, 3'b0, 1'b0, 1'b0, 2'b0, 2'b0, 3'b0, 13'd0});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!cke && bus() == 7 && cnt < 1000) begin cnt++; @(negedge clk); end
    check("R2", "cke-low cycles", cnt, PW);
    cnt = 0;
    while (cke && bus() == 7 && cnt < 1000) begin cnt++; @(negedge clk); end
    check("R2", "cke-high wait", cnt, CW);
    for (int s = 0; s < 11; s++) begin
      e_ba = 0; e_addr = 0; e_gap = GW; e_pins = 0;
      case (s)
        0, 5: begin e_pins = 2; e_addr = 1024; end
        1:    e_ba = 2;
        2:    e_ba = 3;
        3:    begin e_ba = 1; e_addr = ext1_exp(0); end
        4:    e_addr = main_exp(1);
        6, 7: begin e_pins = 1; e_gap = RW; end
        8:    e_addr = main_exp(0);
        9:    begin e_ba = 1; e_addr = ext1_exp(7); end
        default: begin e_ba = 1; e_addr = ext1_exp(0); e_gap = FW; end
      endcase
      check("R3", $sformatf("step %0d pins", s), bus(), e_pins);
      check("R4", $sformatf("step %0d ba", s), ba, e_ba);
      check((s == 1 || s == 2) ? "R7" : (s == 9 || s == 10) ? "R8" : (s == 3) ? "R6" : "R5",
            $sformatf("step %0d addr", s), addr, e_addr);
      @(negedge clk);
      cnt = 0;
      while (bus() == 7 && !ready && cnt < 1000) begin
        // R11: stray start mid-sequence
        start = (s == 4 && cnt == 0);
        cnt++;
        @(negedge clk);
      end
      start = 1'b0;
      check(s == 10 ? "R10" : "R9", $sformatf("gap after step %0d", s), cnt, e_gap);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    // R10 R11 R12: ready held, bus quiet, start ignored
    check("R11", "after ready", {bus(), 3'b0, cke, ready, ba, addr}, {32'h7, 3'b0, 1'b1, 1'b1, 2'b0, 13'd0});
  endtask

  initial begin
    for (int i = 0; i < RUNS; i++) run_one(i);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    summary();
  end
endmodule